// File: doc/BRIEF.md
# TDM Slot Window Selector

This block decides, slot by slot, which time slots of a time-division-multiplexed serial frame carry data. A channel counter runs across a 1024-slot frame. It clears on a frame-sync pulse and advances on a slot-boundary strobe. A programmable window picks a contiguous run of channels inside that range. The window length is a multiple of 8 channels, from 8 up to 128. The window start is any channel from 0 to 1023. A 128-bit select mask, indexed relative to the window start, then enables individual channels inside it.

The block reports the current channel number and whether that channel is active. It also gives the channel's index inside the window and the number of buffer words a frame needs, which equals the window length. The window configuration is frozen while the block is enabled. It is taken from the configuration inputs on the clock edge where the block sees enable high for the first time.

Control is a four-state machine:
- IDLE: disabled. The configuration register follows the inputs and the counter is held at 0.
- WAIT: armed, waiting for the first frame sync.
- RUN: counting slots.
- DONE: the counter has passed channel 1023 and waits for the next frame sync.

The transitions are:
- arm: IDLE to WAIT, when enable is high.
- start: WAIT to RUN, on frame sync.
- restart: RUN or DONE to RUN, on frame sync.
- exhaust: RUN to DONE, on a strobe at channel 1023.
- disarm: any state to IDLE, when enable is low.

Top module: `tdm_slot_window`

## Requirements
- R1: While reset is asserted, chan_num, chan_active and win_index are all 0.
- R2: win_words equals 8 × (WSIZE + 1) for the WSIZE value held in the configuration register. For example, WSIZE 3 gives 32 and WSIZE 15 gives 128.
- R3: On a clock edge where enable is high and frame_sync is high outside IDLE, the counter clears to 0 and the state becomes RUN. Frame sync takes priority over a simultaneous slot strobe. In RUN, each slot strobe advances chan_num by one.
- R4: A strobe at channel 1023 leaves chan_num at 1023 and moves to DONE. There, further strobes are ignored and chan_active stays 0 until the next frame sync.
- R5: The window covers absolute channels WOFF through WOFF + 8 × (WSIZE + 1) − 1. For example, WSIZE 0 with WOFF 93 covers channels 93 to 100.
- R6: Mask bit i belongs to channel WOFF + i. chan_active is 1 only in RUN, with chan_num inside the window and that mask bit set. win_index is chan_num − WOFF inside the window and 0 outside it.
- R7: Mask bits at or above the window length never make any channel active.
- R8: The configuration is captured on the edge where enable is first seen high from IDLE. Changes to cfg_wsize and cfg_woff while enabled change neither win_words nor the active channels.
- R9: With enable low, the block returns to IDLE at the next edge, with chan_num 0 and chan_active 0. Frame syncs and strobes while disabled, or while in WAIT before a frame sync, leave chan_num at 0.
- R10: A window that would reach past channel 1023 is cut at 1023. WOFF 896 with WSIZE 15 uses all 128 channels, with channel 1023 at index 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; its rising edge captures the configuration |
| frame_sync | input | 1 | Frame start pulse, clears the channel counter |
| slot_strobe | input | 1 | Slot boundary, advances the channel counter |
| cfg_wsize | input | 4 | Window size code (length = 8 × (code + 1)) |
| cfg_woff | input | 10 | First channel of the window |
| sel_mask | input | 128 | Per-channel enable, bit i for window channel i |
| chan_num | output | 10 | Current channel number |
| chan_active | output | 1 | Current channel is enabled |
| win_index | output | 7 | Position of the current channel inside the window |
| win_words | output | 8 | Buffer words needed per frame |

## Verification
A behavioural model in the bench compares all four outputs on every clock. Any wrong internal state therefore shows at the ports within one cycle:
- A miscounted counter shows as a wrong chan_num at the next compare.
- A configuration captured on the wrong edge, or one that tracks the inputs while enabled, shows in win_words one cycle after the bad load.
- A wrong window or state decode shows as chan_active or win_index differing on the first slot where the window edges, the mask bits or the end of the counter matter.

Directed frames aim at these edges: channels 93 to 101, the end of the counter, a cut window and a full window at offset 896. A long random phase toggles enable, frame sync and the configuration inputs.

// File: rtl/tdm_win_pkg.sv
`timescale 1ns/1ps
package tdm_win_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } slot_state_e;
endpackage

// File: rtl/tdm_win_cfg.sv
`timescale 1ns/1ps
module tdm_win_cfg #(
    parameter int SIZE_W = 4,
    parameter int OFF_W  = 10,
    parameter int GRAN   = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] size_in,
    input  logic [OFF_W-1:0]  off_in,
    output logic [OFF_W-1:0]  off_q,
    output logic [LEN_W-1:0]  win_len
);
    logic [SIZE_W-1:0] size_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            size_q <= size_in;
            off_q  <= off_in;
        end
    end

    assign win_len = LEN_W'(GRAN) * (LEN_W'(size_q) + LEN_W'(1));
endmodule

// File: rtl/tdm_slot_fsm.sv
`timescale 1ns/1ps
module tdm_slot_fsm
    import tdm_win_pkg::*;
#(
    parameter int CHAN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              frame_sync,
    input  logic              slot_strobe,
    output slot_state_e       state_q,
    output logic [CHAN_W-1:0] cnt_q,
    output logic              cfg_load,
    output logic              running
);
    localparam logic [CHAN_W-1:0] LAST_CHAN = {CHAN_W{1'b1}};

    slot_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_WAIT;
                ST_WAIT: if (frame_sync) state_d = ST_RUN;
                ST_RUN: begin
                    if (frame_sync)
                        state_d = ST_RUN;
                    else if (slot_strobe && cnt_q == LAST_CHAN)
                        state_d = ST_DONE;
                end
                ST_DONE: if (frame_sync) state_d = ST_RUN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!enable || state_q == ST_IDLE)
            cnt_q <= '0;
        else if (frame_sync)
            cnt_q <= '0;
        else if (state_q == ST_RUN && slot_strobe && cnt_q != LAST_CHAN)
            cnt_q <= cnt_q + CHAN_W'(1);
    end

    always_comb begin
        cfg_load = (state_q == ST_IDLE);
        running  = (state_q == ST_RUN);
    end

    // R3
    sync_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && frame_sync && state_q != ST_IDLE) |=> (state_q == ST_RUN && cnt_q == '0));

    // R4
    end_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !frame_sync && slot_strobe && state_q == ST_RUN && cnt_q == LAST_CHAN)
        |=> (state_q == ST_DONE && cnt_q == LAST_CHAN));

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == ST_IDLE && cnt_q == '0));
endmodule

// File: rtl/tdm_win_decode.sv
`timescale 1ns/1ps
module tdm_win_decode #(
    parameter int CHAN_W  = 10,
    parameter int WIN_MAX = 128,
    parameter int LEN_W   = 8,
    parameter int IDX_W   = 7
) (
    input  logic [CHAN_W-1:0]  cnt,
    input  logic [CHAN_W-1:0]  off,
    input  logic [LEN_W-1:0]   win_len,
    input  logic [WIN_MAX-1:0] mask,
    input  logic               running,
    output logic [IDX_W-1:0]   idx,
    output logic               active
);
    logic [CHAN_W:0] rel;
    logic            in_win;

    always_comb begin
        rel    = {1'b0, cnt} - {1'b0, off};
        in_win = !rel[CHAN_W] && (rel < (CHAN_W+1)'(win_len));
        idx    = in_win ? rel[IDX_W-1:0] : '0;
        active = running && in_win && mask[idx];
    end
endmodule

// File: rtl/tdm_slot_window.sv
`timescale 1ns/1ps
module tdm_slot_window
    import tdm_win_pkg::*;
#(
    parameter int CHAN_W  = 10,
    parameter int WIN_MAX = 128,
    parameter int GRAN    = 8,
    parameter int SIZE_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        frame_sync,
    input  logic                        slot_strobe,
    input  logic [SIZE_W-1:0]           cfg_wsize,
    input  logic [CHAN_W-1:0]           cfg_woff,
    input  logic [WIN_MAX-1:0]          sel_mask,
    output logic [CHAN_W-1:0]           chan_num,
    output logic                        chan_active,
    output logic [$clog2(WIN_MAX)-1:0]  win_index,
    output logic [$clog2(WIN_MAX+1)-1:0] win_words
);
    localparam int IDX_W = $clog2(WIN_MAX);
    localparam int LEN_W = $clog2(WIN_MAX + 1);

    slot_state_e       state;
    logic              cfg_load;
    logic              running;
    logic [CHAN_W-1:0] win_off;

    tdm_slot_fsm #(.CHAN_W(CHAN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .frame_sync(frame_sync), .slot_strobe(slot_strobe),
        .state_q(state), .cnt_q(chan_num),
        .cfg_load(cfg_load), .running(running)
    );

    tdm_win_cfg #(.SIZE_W(SIZE_W), .OFF_W(CHAN_W), .GRAN(GRAN), .LEN_W(LEN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .size_in(cfg_wsize), .off_in(cfg_woff),
        .off_q(win_off), .win_len(win_words)
    );

    tdm_win_decode #(.CHAN_W(CHAN_W), .WIN_MAX(WIN_MAX), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_dec (
        .cnt(chan_num), .off(win_off), .win_len(win_words),
        .mask(sel_mask), .running(running),
        .idx(win_index), .active(chan_active)
    );

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(win_words) && $stable(win_off)));

    // R6
    act_maps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_active |-> (sel_mask[win_index] && chan_num == win_off + CHAN_W'(win_index)));

    // R10
    act_inside_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_active |-> (LEN_W'(win_index) < win_words && state == ST_RUN));
endmodule

// File: tb/tdm_slot_window_tb.sv
`timescale 1ns/1ps
module tdm_slot_window_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         frame_sync = 1'b0;
    logic         slot_strobe = 1'b0;
    logic [3:0]   cfg_wsize = '0;
    logic [9:0]   cfg_woff = '0;
    logic [127:0] sel_mask = '0;
    logic [9:0]   chan_num;
    logic         chan_active;
    logic [6:0]   win_index;
    logic [7:0]   win_words;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int m_st = 0;
    int m_cnt = 0;
    int m_ws = 0;
    int m_wo = 0;

    always #10 clk = ~clk;

    tdm_slot_window u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .frame_sync(frame_sync), .slot_strobe(slot_strobe),
        .cfg_wsize(cfg_wsize), .cfg_woff(cfg_woff), .sel_mask(sel_mask),
        .chan_num(chan_num), .chan_active(chan_active),
        .win_index(win_index), .win_words(win_words)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Reference model: 0 idle, 1 waiting, 2 running, 3 exhausted
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_ws = 0; m_wo = 0;
        end else begin
            if (m_st == 0) begin
                m_ws = cfg_wsize;
                m_wo = cfg_woff;
            end
            if (!enable) begin
                m_st = 0; m_cnt = 0;
            end else if (m_st == 0) begin
                m_st = 1; m_cnt = 0;
            end else if (frame_sync) begin
                m_st = 2; m_cnt = 0;
            end else if (m_st == 2 && slot_strobe) begin
                if (m_cnt == 1023) m_st = 3;
                else m_cnt = m_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            int len;
            bit inw;
            int e_idx;
            int e_act;
            len   = 8 * (m_ws + 1);
            inw   = (m_cnt >= m_wo) && (m_cnt < m_wo + len);
            e_idx = inw ? m_cnt - m_wo : 0;
            e_act = (m_st == 2 && inw && sel_mask[e_idx]) ? 1 : 0;
            chk("R3 chan_num", int'(chan_num), m_cnt);
            chk("R6 chan_active", int'(chan_active), e_act);
            chk("R6 win_index", int'(win_index), e_idx);
            chk("R2 win_words", int'(win_words), len);
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic slots(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); #1 slot_strobe = 1'b1;
        end
        @(negedge clk); #1 slot_strobe = 1'b0;
    endtask

    task automatic fsync();
        @(negedge clk); #1 frame_sync = 1'b1;
        @(negedge clk); #1 frame_sync = 1'b0;
    endtask

    task automatic arm(input int ws, input int wo, input logic [127:0] m);
        @(negedge clk); #1 enable = 1'b0;
        tick();
        cfg_wsize = 4'(ws); cfg_woff = 10'(wo); sel_mask = m;
        enable = 1'b1;
        tick();
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [127:0] m;
        repeat (3) tick();
        chk("R1 chan_num", int'(chan_num), 0);
        chk("R1 chan_active", int'(chan_active), 0);
        chk("R1 win_index", int'(win_index), 0);
        rst_n = 1'b1;
        tick();

        // Window 93..100, mask low byte 1010_0101, all higher bits set
        m = '1; m[7:0] = 8'hA5;
        arm(0, 93, m);
        slots(5);
        chk("R9 wait ignores strobes", int'(chan_num), 0);
        fsync();
        chk("R3 cleared", int'(chan_num), 0);
        slots(93);
        chk("R5 first ch active", int'(chan_active), 1);
        chk("R6 index at start", int'(win_index), 0);
        slots(1);
        chk("R6 mask bit1 clear", int'(chan_active), 0);
        chk("R6 index 1", int'(win_index), 1);
        slots(6);
        chk("R5 last ch active", int'(chan_active), 1);
        chk("R5 index 7", int'(win_index), 7);
        slots(1);
        chk("R7 bit8 ignored", int'(chan_active), 0);
        cfg_wsize = 4'd15; cfg_woff = 10'd0;
        tick();
        chk("R8 size frozen", int'(win_words), 8);
        slots(1);
        chk("R8 window frozen", int'(chan_active), 0);
        slots(921);
        chk("R4 reach end", int'(chan_num), 1023);
        slots(2);
        chk("R4 hold end", int'(chan_num), 1023);
        chk("R4 inactive past end", int'(chan_active), 0);
        fsync();
        chk("R3 restart", int'(chan_num), 0);
        slots(5);
        @(negedge clk); #1 frame_sync = 1'b1; slot_strobe = 1'b1;
        @(negedge clk); #1 frame_sync = 1'b0; slot_strobe = 1'b0;
        chk("R3 sync beats strobe", int'(chan_num), 0);

        // Disabled behaviour
        enable = 1'b0;
        tick(); tick();
        chk("R9 counter cleared", int'(chan_num), 0);
        chk("R9 inactive", int'(chan_active), 0);
        chk("R2 idle tracks size", int'(win_words), 128);
        fsync();
        slots(3);
        chk("R9 disabled ignores", int'(chan_num), 0);

        // 32-channel window at 0
        arm(3, 0, '1);
        chk("R2 words 32", int'(win_words), 32);
        fsync();
        slots(31);
        chk("R5 ch31 active", int'(chan_active), 1);
        chk("R6 index 31", int'(win_index), 31);
        slots(1);
        chk("R7 ch32 outside", int'(chan_active), 0);

        // Full window at 896
        m = '0; m[0] = 1'b1; m[127] = 1'b1;
        arm(15, 896, m);
        fsync();
        slots(896);
        chk("R10 ch896 active", int'(chan_active), 1);
        slots(127);
        chk("R10 ch1023 active", int'(chan_active), 1);
        chk("R10 index 127", int'(win_index), 127);
        slots(1);
        chk("R4 done inactive", int'(chan_active), 0);

        // Window cut at the end
        arm(15, 1000, '1);
        fsync();
        slots(1023);
        chk("R10 cut last active", int'(chan_active), 1);
        chk("R10 cut index", int'(win_index), 23);
        slots(1);
        chk("R10 nothing past end", int'(chan_active), 0);

        // Random phase, compared by the model every clock
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk); #1;
            enable      = ($urandom % 300) != 0;
            frame_sync  = ($urandom % 400) == 0;
            slot_strobe = ($urandom % 5) != 0;
            if ($urandom % 40 == 0) begin
                cfg_wsize = 4'($urandom);
                cfg_woff  = 10'($urandom);
            end
            if ($urandom % 60 == 0)
                sel_mask = {$urandom, $urandom, $urandom, $urandom};
        end
        tick();
        summary();
    end
endmodule